// File: doc/BRIEF.md
# Per-Processor Device Interrupt Router

This block gathers up to 64 level-free device interrupt events into one shared pending vector. It distributes that vector to four processors, and each processor filters the vector through its own enable mask. Devices signal pulses. A set pulse marks a line pending, and a clear pulse retires it. For each processor, the routed view is the AND of that processor's mask with the pending vector. A single level output per processor stays high while any routed bit is set.

Software reaches the block through a small request/response register bus that carries only full 64-bit words. The bus can write the masks. The routed views and the pending vector can be read but not written. Every request gets a response one cycle later, and the response carries read data and an error flag.

Top module: `irq_router`

## Requirements
- R1: A one-cycle pulse on `dev_set[n]` sets pending bit n at the next clock edge. The pending vector reads back at register index 8, where the index is `req_addr >> 6`.
- R2: A pulse on `dev_clr[n]` clears pending bit n. If set and clear for the same line arrive in one cycle, the clear takes effect. A clear for a line that is not pending changes no state.
- R3: The routed view of processor c reads back at index 4+c and always equals mask c AND the pending vector.
- R4: `cpu_irq[c]` is high exactly when the routed view of processor c was nonzero in the previous cycle, so it lags the register state by one clock.
- R5: A full-width write to index c (0..3) replaces mask c, and the mask reads back at the same index. Enabling a pending bit raises the processor's interrupt, and disabling the last routed bit drops it.
- R6: A request whose `req_size` is not 3 (encoding 0=1, 1=2, 2=4, 3=8 bytes) returns an error and leaves all state unchanged.
- R7: A write to a routed view (index 4..7) or to the pending vector (index 8) returns an error and changes nothing.
- R8: An access to an index above 8 returns read data zero with the error flag set for that single response cycle. A write to such an index changes nothing.
- R9: Reset clears every mask, the pending vector, all interrupt outputs and the response.
- R10: `rsp_valid` is high in exactly the cycle after each request. Address bits 5..0 do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_set | input | 64 | Per-line set pulses from devices |
| dev_clr | input | 64 | Per-line clear pulses from devices |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the block window |
| req_size | input | 2 | Access size code, 3 = 64-bit |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Error on the response |
| rsp_rdata | output | 64 | Read data, zero on writes and errors |
| cpu_irq | output | 4 | Interrupt level per processor |

## Verification
The assertions assume that the device pulses and bus requests are driven only outside reset. They also assume that a request lasts a single cycle, so each response can be matched to the request one cycle before it. The bench drives every input at the falling edge and holds each request for exactly one cycle. Random sizes, indices and pulse patterns, some with set and clear colliding, stay inside those assumptions while still reaching the error paths.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NLINES = 64,
  parameter int NCPU   = 4,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] dev_set,
  input  logic [NLINES-1:0] dev_clr,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [NLINES-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [NLINES-1:0] rsp_rdata,
  output logic [NCPU-1:0]   cpu_irq
);
  localparam int IW = AW - 6;
  localparam logic [IW-1:0] ROUTED_LO = IW'(NCPU);
  localparam logic [IW-1:0] RAW_IDX   = IW'(2 * NCPU);

  logic [NLINES-1:0]            raw;
  logic [NCPU-1:0][NLINES-1:0]  mask;
  logic [NCPU-1:0][NLINES-1:0]  routed;
  logic [NCPU-1:0]              any_routed;

  wire [IW-1:0] idx       = req_addr[AW-1:6];
  wire          full      = (req_size == 2'd3);
  wire          is_mask   = idx < ROUTED_LO;
  wire          is_routed = (idx >= ROUTED_LO) && (idx < RAW_IDX);
  wire          is_raw    = (idx == RAW_IDX);
  wire          bad       = !full || (req_write ? !is_mask : !(is_mask || is_routed || is_raw));
  wire          wr_ok     = req_valid && req_write && !bad;

  logic [NLINES-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (idx == IW'(c))        rd_word = mask[c];
      if (idx == IW'(NCPU + c)) rd_word = routed[c];
    end
    if (is_raw) rd_word = raw;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign routed[c]     = mask[c] & raw;
    assign any_routed[c] = |routed[c];

    always_ff @(posedge clk) begin
      if (!rst_n)
        mask[c] <= '0;
      else if (wr_ok && idx == IW'(c))
        mask[c] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw       <= '0;
      cpu_irq   <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      raw       <= (raw | dev_set) & ~dev_clr;
      cpu_irq   <= any_routed;
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= (req_valid && !req_write && !bad) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NLINES = 64,
  parameter int NCPU   = 4,
  parameter int AW     = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NLINES-1:0]           dev_set,
  input logic [NLINES-1:0]           dev_clr,
  input logic                        req_valid,
  input logic                        req_write,
  input logic [AW-1:0]               req_addr,
  input logic [1:0]                  req_size,
  input logic                        rsp_valid,
  input logic                        rsp_err,
  input logic [NLINES-1:0]           rsp_rdata,
  input logic [NCPU-1:0]             cpu_irq,
  input logic [NLINES-1:0]           raw,
  input logic [NCPU-1:0][NLINES-1:0] mask
);
  AST_SET_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_set & ~dev_clr) != '0) |=> ((raw & $past(dev_set & ~dev_clr)) == $past(dev_set & ~dev_clr))); // R1
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_clr != '0) |=> ((raw & $past(dev_clr)) == '0)); // R2
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |=> (cpu_irq == '0)); // R4
  AST_NARROW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd3) |=> (rsp_valid && rsp_err && $stable(mask))); // R6
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[AW-1:6] >= (AW-6)'(NCPU)) |=> (rsp_err && $stable(mask))); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R8
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10
  AST_RSP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R10
endmodule

bind irq_router irq_router_chk #(.NLINES(NLINES), .NCPU(NCPU), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_set(dev_set), .dev_clr(dev_clr),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .req_size(req_size), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .cpu_irq(cpu_irq), .raw(raw), .mask(mask)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] dev_set = '0, dev_clr = '0;
  logic        req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [3:0]  cpu_irq;

  int checks = 0, errors = 0;
  logic [63:0] m_mask [4];
  logic [63:0] m_raw;

  always #10 clk = ~clk;

  irq_router dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_word(int idx);
    if (idx < 4) return m_mask[idx];
    if (idx < 8) return m_mask[idx-4] & m_raw;
    if (idx == 8) return m_raw;
    return '0;
  endfunction

  function automatic logic exp_err(logic wr, int idx, logic [1:0] sz);
    if (sz != 2'd3) return 1'b1;
    if (wr) return idx >= 4;
    return idx > 8;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = |(m_mask[c] & m_raw);
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int c = 0; c < 4; c++) m_mask[c] = '0;
    m_raw = '0;
  endtask

  task automatic irq_chk(string req);
    @(posedge clk);
    @(negedge clk);
    chk(req, {60'd0, cpu_irq}, {60'd0, exp_irq()});
  endtask

  task automatic bus(string req, logic wr, int idx, logic [5:0] lo, logic [1:0] sz, logic [63:0] wd);
    logic e;
    logic [63:0] rd;
    e  = exp_err(wr, idx, sz);
    rd = (wr || e) ? 64'd0 : exp_word(idx);
    req_valid = 1; req_write = wr; req_addr = {idx[5:0], lo}; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (wr && !e) m_mask[idx] = wd;
    chk({req, " rsp_valid R10"}, {63'd0, rsp_valid}, 64'd1);
    chk({req, " rsp_err"}, {63'd0, rsp_err}, {63'd0, e});
    chk({req, " rsp_rdata"}, rsp_rdata, rd);
    irq_chk({req, " irq R4"});
  endtask

  task automatic dev(string req, logic [63:0] s, logic [63:0] c);
    dev_set = s; dev_clr = c;
    @(posedge clk);
    @(negedge clk);
    dev_set = '0; dev_clr = '0;
    m_raw = (m_raw | s) & ~c;
    irq_chk(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();
    @(negedge clk);
    chk("R9 irq after reset", {60'd0, cpu_irq}, 64'd0);
    chk("R9 rsp after reset", {63'd0, rsp_valid}, 64'd0);
    for (int i = 0; i <= 8; i++) bus("R9 reset read", 0, i, 6'd0, 2'd3, '0);

    dev("R1 set line 5", 64'h20, '0);
    bus("R1 raw read", 0, 8, 6'd0, 2'd3, '0);
    bus("R5 enable cpu0 bit5", 1, 0, 6'd0, 2'd3, 64'h20);
    chk("R5 cpu0 raised", {63'd0, cpu_irq[0]}, 64'd1);
    bus("R3 routed cpu0", 0, 4, 6'd0, 2'd3, '0);
    bus("R5 disable cpu0", 1, 0, 6'd0, 2'd3, 64'h0);
    chk("R5 cpu0 dropped", {63'd0, cpu_irq[0]}, 64'd0);
    bus("R5 mask cpu2", 1, 2, 6'd0, 2'd3, 64'h8000_0000_0000_0021);
    dev("R2 set and clear same line", 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000);
    bus("R2 raw after collision", 0, 8, 6'd0, 2'd3, '0);
    dev("R2 spurious clear", '0, 64'h0000_0100_0000_0000);
    bus("R2 raw after spurious", 0, 8, 6'd0, 2'd3, '0);
    bus("R6 narrow write", 1, 1, 6'd0, 2'd2, 64'hFFFF);
    bus("R6 mask unchanged", 0, 1, 6'd0, 2'd3, '0);
    bus("R6 narrow read", 0, 8, 6'd0, 2'd0, '0);
    bus("R7 write routed", 1, 6, 6'd0, 2'd3, 64'hFFFF);
    bus("R7 write raw", 1, 8, 6'd0, 2'd3, 64'hFFFF);
    bus("R7 raw unchanged", 0, 8, 6'd0, 2'd3, '0);
    bus("R8 undecoded read", 0, 9, 6'd0, 2'd3, '0);
    bus("R8 undecoded write", 1, 40, 6'd0, 2'd3, 64'h1);
    bus("R10 low address bits ignored", 0, 2, 6'h18, 2'd3, '0);

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(1, 0) == 0) begin
        logic [63:0] s, c;
        s = {$urandom, $urandom} & {$urandom, $urandom};
        c = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        dev("R2 random events", s, c);
      end else begin
        logic wr;
        int idx;
        logic [1:0] sz;
        wr  = $urandom_range(1, 0) == 1;
        idx = $urandom_range(11, 0);
        sz  = ($urandom_range(7, 0) == 0) ? 2'($urandom_range(2, 0)) : 2'd3;
        bus("R3 random access", wr, idx, 6'($urandom), sz, {$urandom, $urandom} & {$urandom, $urandom});
      end
    end

    do_reset();
    @(negedge clk);
    chk("R9 irq after second reset", {60'd0, cpu_irq}, 64'd0);
    for (int i = 0; i <= 8; i++) bus("R9 second reset read", 0, i, 6'd0, 2'd3, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule